// File: doc/BRIEF.md
# NOR Flash Block Erase Sequencer

This block is a bus master that wipes one block of a parallel NOR flash and then confirms that the block reads blank. A single-cycle start pulse carries a block word address and a block length in words. The block then drives a simple synchronous flash bus. For each region it writes a status-clear command, issues the two-cycle erase command and polls the status word. Polling ends when the device reports ready or when a programmable poll budget runs out. The block then puts the device back in array-read mode and reads every word of the region, comparing each one against all ones.

If the block address equals a configured boot-region offset, the block does not erase one region of the given length. It instead walks a table of sub-sector lengths, erasing and checking each sub-sector in turn, with each one starting where the previous one ended. Status error bits are turned into a 3-bit result code by a fixed priority. A blank-check failure is reported only when no status error came first. A busy/done handshake tells the requester when the result is valid.

On the flash bus, every command write and every read lasts one cycle. Read data is valid on `fl_rdata_i` in the cycle after `fl_re_o` is high. All command values sit in the low byte of the data bus with the upper bits zero.

Top module: `nor_erase_seq`

## Requirements
- R1: Before every erase command, the cycle immediately before it writes the status-clear command 0x50 to word address 0.
- R2: The erase is issued as 0x20 written to address 0, then 0xD0 written in the next cycle to the first word of the current region.
- R3: After the confirm write, status is polled by reading address 0. Each read is followed one cycle later by examination of the returned data. Polling stops on the first status with bit 7 set, or after max(timeout_i,1) reads, whichever comes first. No write and read are ever driven in the same cycle.
- R4: When polling ends, either way, 0xFF is written to address 0. The block then goes on to the blank check, so a device that never becomes ready does not stall it.
- R5: A status with any bit of mask 0x7E set produces a result code. The code is 1 (unknown hardware fault) if bit 0x20 is clear. Otherwise it is 2 (low voltage) if bit 0x08 is set, else 3 (protected) if bit 0x02 is set, else 4 (erase failure). With no such bit set, the result stays 0 (success).
- R6: Each region word is read in turn and compared with all ones. The first mismatch ends the whole operation at once. It sets result code 5 (verify failure) only if the result is still 0; otherwise the earlier code is kept.
- R7: When blk_addr_i equals boot_ofs_i, the region lengths come from boot_tbl_i. Entry j occupies bits [16j+15:16j]. The entries are processed in index order, stopping at the first zero entry or after the last of the NSUB entries. Each entry gets its own clear, erase, poll, reset and check sequence at consecutive addresses.
- R8: busy_o is high from the cycle after an accepted start until the cycle holding the one-cycle done_o pulse, inclusive. result_o is valid with done_o and holds until the next accepted start. A start while busy is ignored.
- R9: A non-boot start with zero length completes with result 0 and no flash bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to erase a block |
| blk_addr_i | input | AW | Word address of the block |
| blk_len_i | input | LW | Block length in words (non-boot blocks) |
| timeout_i | input | TW | Maximum number of status reads per erase |
| boot_ofs_i | input | AW | Block address that selects the sub-sector table |
| boot_tbl_i | input | NSUB*LW | Packed sub-sector lengths, entry 0 in the low bits |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | Result code (0 ok, 1 hw, 2 low voltage, 3 protected, 4 erase, 5 verify) |
| fl_addr_o | output | AW | Flash word address |
| fl_wdata_o | output | DW | Flash write data |
| fl_rdata_i | input | DW | Flash read data, valid one cycle after a read strobe |
| fl_we_o | output | 1 | Flash write strobe |
| fl_re_o | output | 1 | Flash read strobe |

## Verification
The bench runs a flash model that can be set to stay busy for a chosen number of status reads, to report chosen error bits, and to hold one word that is not blank. Runs with zero and with several busy reads show that polling stops on the ready bit. A device that never becomes ready, with budgets of 5 and 0, separates a timeout exit from a stall and checks the minimum of one read. Status patterns 0x10, 0x20, 0x22, 0x28 and 0x2A tell the decode priority apart, and a stuck word combined with an error status shows which result wins. Boot-region runs cover a table ended by a zero entry, a table full of non-zero entries, and a stuck word in the middle sub-sector. These show that the walk stops correctly and that addresses carry on from one sub-sector to the next.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    typedef enum logic [2:0] {
        RES_OK     = 3'd0,
        RES_HW     = 3'd1,
        RES_LOWV   = 3'd2,
        RES_PROT   = 3'd3,
        RES_ERASE  = 3'd4,
        RES_VERIFY = 3'd5
    } res_e;

    typedef enum logic [3:0] {
        S_IDLE, S_SEL, S_CLR, S_ERS, S_CONF, S_PRD, S_PCHK,
        S_RST, S_VRD, S_VCHK, S_NEXT, S_FIN
    } seq_st_e;

    typedef struct packed {
        logic ready;
        logic any_err;
        res_e code;
    } stat_dec_t;

    localparam logic [7:0] CMD_CLR_STAT = 8'h50;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
    localparam logic [7:0] CMD_READ_ARR = 8'hFF;

    localparam logic [7:0] ST_READY    = 8'h80;
    localparam logic [7:0] ST_ERR_MASK = 8'h7E;
    localparam logic [7:0] ST_ERASE_F  = 8'h20;
    localparam logic [7:0] ST_LOWV_F   = 8'h08;
    localparam logic [7:0] ST_PROT_F   = 8'h02;

    // Priority decode of the error bits of one status byte.
    function automatic res_e decode_err(input logic [7:0] s);
        res_e r;
        if ((s & ST_ERR_MASK) == 8'h00)      r = RES_OK;
        else if ((s & ST_ERASE_F) == 8'h00)  r = RES_HW;
        else if ((s & ST_LOWV_F) != 8'h00)   r = RES_LOWV;
        else if ((s & ST_PROT_F) != 8'h00)   r = RES_PROT;
        else                                 r = RES_ERASE;
        return r;
    endfunction

endpackage

// File: rtl/nor_status_decode.sv
module nor_status_decode
    import nor_erase_pkg::*;
(
    input  logic [7:0] stat_i,
    output stat_dec_t  dec_o
);
    logic unused_bit0;
    assign unused_bit0   = stat_i[0];

    assign dec_o.ready   = (stat_i & ST_READY) != 8'h00;
    assign dec_o.any_err = (stat_i & ST_ERR_MASK) != 8'h00;
    assign dec_o.code    = decode_err(stat_i);
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    input  logic          tick_i,
    output logic          last_o
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    // A budget of zero or one allows exactly one status read.
    assign last_o = (cnt_q <= TW'(1));
endmodule

// File: rtl/nor_region_walker.sv
module nor_region_walker #(
    parameter int LW   = 16,
    parameter int NSUB = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             boot_i,
    input  logic             adv_i,
    input  logic [LW-1:0]    blk_len_i,
    input  logic [NSUB*LW-1:0] tbl_i,
    output logic [LW-1:0]    len_o
);
    localparam int IW = (NSUB > 1) ? $clog2(NSUB) : 1;

    logic [LW-1:0] tbl_arr [NSUB];

    genvar g;
    generate
        for (g = 0; g < NSUB; g++) begin : g_unpack
            assign tbl_arr[g] = tbl_i[g*LW +: LW];
        end
    endgenerate

    logic [IW-1:0] idx_q;
    logic          boot_q;
    logic [LW-1:0] len_q;
    logic          has_next;
    logic [LW-1:0] next_len;

    assign has_next = boot_q && (int'(idx_q) < NSUB - 1);
    assign next_len = has_next ? tbl_arr[idx_q + IW'(1)] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            boot_q <= 1'b0;
            len_q  <= '0;
        end else if (load_i) begin
            idx_q  <= '0;
            boot_q <= boot_i;
            len_q  <= boot_i ? tbl_arr[0] : blk_len_i;
        end else if (adv_i) begin
            if (has_next) idx_q <= idx_q + IW'(1);
            len_q <= next_len;
        end
    end

    assign len_o = len_q;
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
    import nor_erase_pkg::*;
#(
    parameter int AW   = 24,
    parameter int DW   = 16,
    parameter int LW   = 16,
    parameter int TW   = 20,
    parameter int NSUB = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [AW-1:0]        blk_addr_i,
    input  logic [LW-1:0]        blk_len_i,
    input  logic [TW-1:0]        timeout_i,
    input  logic [AW-1:0]        boot_ofs_i,
    input  logic [NSUB*LW-1:0]   boot_tbl_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [2:0]           result_o,
    output logic [AW-1:0]        fl_addr_o,
    output logic [DW-1:0]        fl_wdata_o,
    input  logic [DW-1:0]        fl_rdata_i,
    output logic                 fl_we_o,
    output logic                 fl_re_o
);
    localparam logic [DW-1:0] BLANK = '1;

    seq_st_e   st_q;
    logic [AW-1:0] ptr_q;
    logic [LW-1:0] rem_q;
    res_e      res_q;
    stat_dec_t dec_now;
    stat_dec_t dec_q;
    logic [LW-1:0] walk_len;
    logic      tmr_last;
    logic      accept;

    assign accept = (st_q == S_IDLE) && start_i;

    nor_status_decode u_dec (
        .stat_i (fl_rdata_i[7:0]),
        .dec_o  (dec_now)
    );

    nor_poll_timer #(.TW(TW)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load_i (st_q == S_CONF),
        .val_i  (timeout_i),
        .tick_i ((st_q == S_PCHK) && !dec_now.ready),
        .last_o (tmr_last)
    );

    nor_region_walker #(.LW(LW), .NSUB(NSUB)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .load_i    (accept),
        .boot_i    (blk_addr_i == boot_ofs_i),
        .adv_i     (st_q == S_NEXT),
        .blk_len_i (blk_len_i),
        .tbl_i     (boot_tbl_i),
        .len_o     (walk_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            ptr_q <= '0;
            rem_q <= '0;
            res_q <= RES_OK;
            dec_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (start_i) begin
                    ptr_q <= blk_addr_i;
                    res_q <= RES_OK;
                    st_q  <= S_SEL;
                end
                S_SEL: begin
                    rem_q <= walk_len;
                    st_q  <= (walk_len == '0) ? S_FIN : S_CLR;
                end
                S_CLR:  st_q <= S_ERS;
                S_ERS:  st_q <= S_CONF;
                S_CONF: st_q <= S_PRD;
                S_PRD:  st_q <= S_PCHK;
                S_PCHK: begin
                    dec_q <= dec_now;
                    st_q  <= (dec_now.ready || tmr_last) ? S_RST : S_PRD;
                end
                S_RST: begin
                    if (dec_q.any_err) res_q <= dec_q.code;
                    st_q <= S_VRD;
                end
                S_VRD: st_q <= S_VCHK;
                S_VCHK: begin
                    if (fl_rdata_i != BLANK) begin
                        if (res_q == RES_OK) res_q <= RES_VERIFY;
                        st_q <= S_FIN;
                    end else begin
                        ptr_q <= ptr_q + AW'(1);
                        rem_q <= rem_q - LW'(1);
                        st_q  <= (rem_q == LW'(1)) ? S_NEXT : S_VRD;
                    end
                end
                S_NEXT: st_q <= S_SEL;
                S_FIN:  st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        fl_we_o    = 1'b0;
        fl_re_o    = 1'b0;
        fl_addr_o  = '0;
        fl_wdata_o = '0;
        case (st_q)
            S_CLR: begin
                fl_we_o    = 1'b1;
                fl_wdata_o = DW'(CMD_CLR_STAT);
            end
            S_ERS: begin
                fl_we_o    = 1'b1;
                fl_wdata_o = DW'(CMD_ERASE);
            end
            S_CONF: begin
                fl_we_o    = 1'b1;
                fl_addr_o  = ptr_q;
                fl_wdata_o = DW'(CMD_CONFIRM);
            end
            S_PRD: fl_re_o = 1'b1;
            S_RST: begin
                fl_we_o    = 1'b1;
                fl_wdata_o = DW'(CMD_READ_ARR);
            end
            S_VRD: begin
                fl_re_o   = 1'b1;
                fl_addr_o = ptr_q;
            end
            default: ;
        endcase
    end

    assign busy_o   = (st_q != S_IDLE);
    assign done_o   = (st_q == S_FIN);
    assign result_o = res_q;
endmodule

// File: rtl/nor_erase_seq_chk.sv
module nor_erase_seq_chk
    import nor_erase_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [2:0]    result_o,
    input logic [AW-1:0] fl_addr_o,
    input logic [DW-1:0] fl_wdata_o,
    input logic          fl_we_o,
    input logic          fl_re_o
);
    AST_CLEAR_BEFORE_ERASE: assert property (@(posedge clk) disable iff (rst)
        (fl_we_o && fl_wdata_o == DW'(CMD_ERASE)) |->
        $past(fl_we_o && fl_wdata_o == DW'(CMD_CLR_STAT) && fl_addr_o == '0)); // R1

    AST_CONFIRM_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (fl_we_o && fl_wdata_o == DW'(CMD_ERASE)) |=>
        (fl_we_o && fl_wdata_o == DW'(CMD_CONFIRM))); // R2

    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(fl_we_o && fl_re_o)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(result_o)); // R8

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!fl_we_o && !fl_re_o)); // R9
endmodule

bind nor_erase_seq nor_erase_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .fl_addr_o  (fl_addr_o),
    .fl_wdata_o (fl_wdata_o),
    .fl_we_o    (fl_we_o),
    .fl_re_o    (fl_re_o)
);

// File: tb/tb_nor_erase_seq.sv
module tb_nor_erase_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int LW = 16;
    localparam int TW = 20;
    localparam int NSUB = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [AW-1:0] blk_addr_i = '0;
    logic [LW-1:0] blk_len_i = '0;
    logic [TW-1:0] timeout_i = '0;
    logic [AW-1:0] boot_ofs_i = AW'(24'h100);
    logic [NSUB*LW-1:0] boot_tbl_i = '0;
    logic busy_o, done_o, fl_we_o, fl_re_o;
    logic [2:0] result_o;
    logic [AW-1:0] fl_addr_o;
    logic [DW-1:0] fl_wdata_o;
    logic [DW-1:0] fl_rdata_i;

    nor_erase_seq #(.AW(AW), .DW(DW), .LW(LW), .TW(TW), .NSUB(NSUB)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .blk_addr_i(blk_addr_i),
        .blk_len_i(blk_len_i), .timeout_i(timeout_i), .boot_ofs_i(boot_ofs_i),
        .boot_tbl_i(boot_tbl_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o),
        .fl_rdata_i(fl_rdata_i), .fl_we_o(fl_we_o), .fl_re_o(fl_re_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nvec = 0;
    int nfail = 0;
    int dones = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    int            m_busy_polls = 0;
    logic [7:0]    m_err = 8'h00;
    bit            m_stuck_en = 1'b0;
    logic [AW-1:0] m_stuck_addr = '0;
    logic          st_mode, armed;
    int            polls_left;

    always @(posedge clk) begin
        if (rst) begin
            st_mode    <= 1'b0;
            armed      <= 1'b0;
            polls_left <= 0;
            fl_rdata_i <= '1;
        end else begin
            if (fl_we_o) begin
                case (fl_wdata_o[7:0])
                    8'h50: st_mode <= 1'b1;
                    8'h20: begin st_mode <= 1'b1; armed <= 1'b1; end
                    8'hD0: if (armed) begin armed <= 1'b0; polls_left <= m_busy_polls; end
                    8'hFF: begin st_mode <= 1'b0; armed <= 1'b0; end
                    default: ;
                endcase
            end
            if (fl_re_o) begin
                if (st_mode) begin
                    if (polls_left > 0) begin
                        fl_rdata_i <= {8'h00, m_err & 8'h7E};
                        polls_left <= polls_left - 1;
                    end else begin
                        fl_rdata_i <= {8'h00, 8'h80 | m_err};
                    end
                end else begin
                    fl_rdata_i <= (m_stuck_en && fl_addr_o == m_stuck_addr) ? 16'hFFEF : '1;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit            is_done;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        int            polls;
        string         req;
    } item_t;

    item_t expq[$];

    function automatic void push_wr(input logic [AW-1:0] a, input logic [7:0] d,
                                    input int p, input string req);
        item_t it;
        it.is_done = 1'b0; it.addr = a; it.data = d; it.polls = p; it.req = req;
        expq.push_back(it);
    endfunction

    function automatic int exp_code(input logic [7:0] s);
        if ((s & 8'h7E) == 8'h00) return 0;
        if (!s[5]) return 1;
        if (s[3]) return 2;
        if (s[1]) return 3;
        return 4;
    endfunction

    int poll_cnt = 0;
    bit in_poll = 1'b0;

    always @(negedge clk) begin
        item_t it;
        if (!rst) begin
            if (fl_re_o && in_poll) poll_cnt++;
            if (fl_we_o) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9", "unexpected write", fl_wdata_o, 0);
                end else begin
                    it = expq.pop_front();
                    check(!it.is_done, it.req, "write where done expected", fl_wdata_o, 0);
                    check(fl_wdata_o == DW'(it.data), it.req, "write data", fl_wdata_o, it.data);
                    check(fl_addr_o == it.addr, it.req, "write address", fl_addr_o, it.addr);
                    if (it.data == 8'hFF && it.polls >= 0)
                        check(poll_cnt == it.polls, "R3", "status reads", poll_cnt, it.polls);
                end
                if (fl_wdata_o[7:0] == 8'hD0) begin in_poll = 1'b1; poll_cnt = 0; end
                if (fl_wdata_o[7:0] == 8'hFF) in_poll = 1'b0;
            end
            if (done_o) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R8", "unexpected done", 1, 0);
                end else begin
                    it = expq.pop_front();
                    check(it.is_done, it.req, "done before expected write", 1, it.data);
                    check(result_o == it.data[2:0], it.req, "result code", result_o, it.data);
                end
                dones++;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic run_job(input logic [AW-1:0] a, input int len, input int tmo,
                           input int bpolls, input logic [7:0] err, input bit sen,
                           input logic [AW-1:0] saddr, input bit restart,
                           input string tag);
        int lens[$];
        int p, r, target;
        logic [AW-1:0] ptr;
        bit stop;
        item_t d;
        if (a == boot_ofs_i) begin
            for (int j = 0; j < NSUB; j++) begin
                if (boot_tbl_i[j*LW +: LW] == '0) break;
                lens.push_back(int'(boot_tbl_i[j*LW +: LW]));
            end
        end else if (len != 0) begin
            lens.push_back(len);
        end
        p = ((tmo < 1) ? 1 : tmo);
        if (bpolls + 1 < p) p = bpolls + 1;
        r = 0; ptr = a; stop = 1'b0;
        foreach (lens[i]) begin
            if (!stop) begin
                push_wr('0, 8'h50, -1, "R1");
                push_wr('0, 8'h20, -1, "R2");
                push_wr(ptr, 8'hD0, -1, "R2");
                push_wr('0, 8'hFF, p, "R4");
                if (exp_code(err) != 0) r = exp_code(err);
                if (sen && saddr >= ptr && saddr < ptr + AW'(lens[i])) begin
                    if (r == 0) r = 5;
                    stop = 1'b1;
                end
                ptr = ptr + AW'(lens[i]);
            end
        end
        d.is_done = 1'b1; d.addr = '0; d.data = 8'(r); d.polls = -1; d.req = tag;
        expq.push_back(d);

        m_busy_polls = bpolls; m_err = err; m_stuck_en = sen; m_stuck_addr = saddr;
        target = dones + 1;
        @(negedge clk);
        blk_addr_i = a; blk_len_i = LW'(len); timeout_i = TW'(tmo); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
        if (restart) begin
            repeat (3) @(negedge clk);
            blk_addr_i = AW'(24'h55); blk_len_i = LW'(9); start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (dones == target);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(busy_o == 1'b0, "R8", "busy after done", busy_o, 0);
            check(result_o == 3'(r), "R8", "result held", result_o, r);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R8", "reset busy/done", {busy_o, done_o}, 0);
        check(fl_we_o == 1'b0 && fl_re_o == 1'b0, "R9", "reset bus idle", {fl_we_o, fl_re_o}, 0);
        check(result_o == 3'd0, "R8", "reset result", result_o, 0);

        // R1 R2 R3 R4 R6: clean erase, ready after some polls
        run_job(AW'(24'h20), 4, 100, 3, 8'h00, 0, '0, 0, "R6");
        run_job(AW'(24'h40), 1, 100, 0, 8'h00, 0, '0, 0, "R3");
        // R5: decode priority
        run_job(AW'(24'h20), 2, 100, 1, 8'h10, 0, '0, 0, "R5");
        run_job(AW'(24'h20), 2, 100, 1, 8'h28, 0, '0, 0, "R5");
        run_job(AW'(24'h20), 2, 100, 1, 8'h22, 0, '0, 0, "R5");
        run_job(AW'(24'h20), 2, 100, 1, 8'h20, 0, '0, 0, "R5");
        run_job(AW'(24'h20), 2, 100, 1, 8'h2A, 0, '0, 0, "R5");
        // R4 R3: device never ready
        run_job(AW'(24'h60), 3, 5, 1000, 8'h00, 0, '0, 0, "R4");
        run_job(AW'(24'h60), 2, 0, 1000, 8'h00, 0, '0, 0, "R3");
        // R6: stuck word, alone and after an erase error
        run_job(AW'(24'h80), 6, 100, 2, 8'h00, 1, AW'(24'h83), 0, "R6");
        run_job(AW'(24'h80), 6, 100, 2, 8'h22, 1, AW'(24'h81), 0, "R6");
        // R9: zero length
        run_job(AW'(24'h90), 0, 100, 2, 8'h00, 0, '0, 0, "R9");
        // R8: start while busy ignored
        run_job(AW'(24'hA0), 4, 100, 2, 8'h00, 0, '0, 1, "R8");
        // R7: boot region, zero-terminated table
        boot_tbl_i = '0;
        boot_tbl_i[0*LW +: LW] = LW'(3);
        boot_tbl_i[1*LW +: LW] = LW'(2);
        boot_tbl_i[2*LW +: LW] = LW'(4);
        boot_tbl_i[4*LW +: LW] = LW'(7);
        run_job(AW'(24'h100), 0, 100, 1, 8'h00, 0, '0, 0, "R7");
        // R7 R6: stuck word in second sub-sector stops the walk
        run_job(AW'(24'h100), 0, 100, 1, 8'h00, 1, AW'(24'h104), 0, "R7");
        // R7: table full of non-zero entries
        for (int j = 0; j < NSUB; j++) boot_tbl_i[j*LW +: LW] = LW'(1);
        run_job(AW'(24'h100), 0, 100, 0, 8'h00, 0, '0, 0, "R7");

        repeat (5) @(negedge clk);
        check(expq.size() == 0, "R8", "leftover expectations", expq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule